// File: doc/BRIEF.md
# Peripheral Pin Ownership Controller

This block sits between the on-chip LCD, serial and synchronous-serial engines and their 22 dedicated pads. For each pad it chooses, every cycle, between two owners. When the engine behind the pad is enabled, the engine drives the pad. When that engine is disabled, software drives the pad through a direction bit and a level bit.

Serial ports 1 to 3 release their transmit and receive pads separately. A port running in one direction only therefore leaves its other pad free for general-purpose use.

Two dual-engine ports can steer their second engine onto six general-purpose pads through a route register. Port 1 moves its asynchronous engine to GPIO 14 and 15. Port 4 moves its synchronous engine to GPIO 10 to 13. Sleep entry or reset cancels both routes, which hands those pads back to the system GPIO logic. All pad outputs are registered, and register reads return one cycle after the request.

Top module: `pin_owner_ctrl`

## Requirements
- R1: After a synchronous reset, every `pin_oe` and `pin_do` bit is 0 and `alt_own` is 0. Both `alt_rxd` bits are 1. The direction, level and route registers all read 0.
- R2: A pad whose engine is disabled follows the software registers. `pin_oe[i]` equals direction bit i (1 means output, 0 means input), and `pin_do[i]` equals level bit i.
- R3: While `lcd_en` is 1, pads 0 to 11 are owned by the LCD engine. Pads 0 to 7 carry the eight data lines, and pads 8 to 11 carry the pixel clock, line clock, frame clock and bias. On these pads `pin_oe` is 1 and `pin_do` equals `periph_do`.
- R4: Serial ports 1 to 3 map to pad pairs 12/13, 14/15 and 16/17, with the even pad for transmit and the odd pad for receive. The transmit enable owns only the even pad (`pin_oe`=1, `pin_do`=`periph_do`). The receive enable owns only the odd pad (`pin_oe`=0, `pin_do`=0). A pad whose enable is 0 stays under software control.
- R5: While `p4_en` is 1, port 4 owns pads 18 to 21. These are transmit on 18, receive on 19, serial clock on 20 and frame on 21. Pads 18, 20 and 21 are outputs carrying `periph_do`, and pad 19 is an input driven with 0.
- R6: The register map is word-addressed. Offset 0 is direction, offset 1 is level, and offset 2 is route (bit 0 selects the port-1 route, bit 1 the port-4 route). Bits above the used width ignore writes and read 0, and any other offset reads 0.
- R7: Register reads return the stored bits whatever the engine enables are.
- R8: With route bit 0 set, `alt_own[5:4]` is 1 (GPIO 14 and 15). `alt_oe[4]`=1 with `alt_do[4]`=`alt_tx_data[3]`, and `alt_oe[5]`=0. `alt_rxd[1]` equals `gpio_in[5]`. When the bit is clear, those `alt_own`/`alt_oe`/`alt_do` bits are 0 and `alt_rxd[1]` is 1.
- R9: With route bit 1 set, `alt_own[3:0]` is 1 (GPIO 10 to 13). Bits 0, 2 and 3 are outputs carrying `alt_tx_data[0]`, `[1]` and `[2]`. Bit 1 is an input, and `alt_rxd[0]` equals `gpio_in[1]`. When the bit is clear, those bits are 0 and `alt_rxd[0]` is 1.
- R10: A cycle with `sleep_req` high clears the route register at that clock edge, and takes priority over a write in the same cycle. The direction and level registers are left unchanged.
- R11: A register write updates the register at the next clock edge, and the pad outputs reflect it one edge later. Read data appears on `bus_rdata` at the edge after `bus_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep entry, clears the routes |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| lcd_en | input | 1 | LCD engine enable |
| p1_tx_en | input | 1 | Port 1 transmit enable |
| p1_rx_en | input | 1 | Port 1 receive enable |
| p2_tx_en | input | 1 | Port 2 transmit enable |
| p2_rx_en | input | 1 | Port 2 receive enable |
| p3_tx_en | input | 1 | Port 3 transmit enable |
| p3_rx_en | input | 1 | Port 3 receive enable |
| p4_en | input | 1 | Port 4 engine enable |
| periph_do | input | 22 | Engine output data per pad |
| pin_oe | output | 22 | Pad output enable |
| pin_do | output | 22 | Pad output data |
| alt_tx_data | input | 4 | {async tx, sync frame, sync clock, sync tx} |
| gpio_in | input | 6 | GPIO 10 to 15 input levels |
| alt_own | output | 6 | GPIO 10 to 15 claimed by a route |
| alt_oe | output | 6 | Output enable for routed GPIO |
| alt_do | output | 6 | Output data for routed GPIO |
| alt_rxd | output | 2 | {async rx, sync rx} from routed GPIO |

## Verification
The checks assume that reset is held for at least one edge before any engine enable is trusted. They also assume that bus strobes and enables change only between edges, so that each registered output reflects exactly the inputs of the previous edge. The stimulus drives every input on the falling edge. It never issues a read and a write to the same offset in one cycle, and it keeps `sleep_req` low except in the cycles that test it. Each enable combination is held for two edges before sampling, so the output stage has settled on the new enables.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int NUM_PINS = 22;
  localparam int LCD_PINS = 12;
  localparam int NUM_ALT  = 6;
  localparam int NUM_EN   = 8;
  localparam int ROUTE_W  = 2;

  // 1 = pad is an output when its engine owns it
  localparam logic [NUM_PINS-1:0] OWNED_OUT = 22'h355FFF;
  // routed GPIO 10..15: which are outputs
  localparam logic [NUM_ALT-1:0] ALT_OUT = 6'b011101;

  localparam int OFF_DIR   = 0;
  localparam int OFF_LEVEL = 1;
  localparam int OFF_ROUTE = 2;

  // enable vector index: 0 lcd, 1..6 ports 1-3 tx/rx, 7 port 4
  function automatic int owner_idx(input int pin);
    if (pin < LCD_PINS)      return 0;
    else if (pin < 18)       return pin - LCD_PINS + 1;
    else                     return NUM_EN - 1;
  endfunction
endpackage

// File: rtl/ppc_regs.sv
module ppc_regs #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_PINS = 22,
  parameter int ROUTE_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sleep_req,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] state_q,
  output logic [ROUTE_W-1:0]  route_q
);
  localparam int PAD_W = DATA_W - NUM_PINS;
  localparam int RPAD_W = DATA_W - ROUTE_W;

  logic [DATA_W-1:0] rd_mux;
  logic              hit_dir, hit_lvl, hit_rt;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_PINS];

  assign hit_dir = (bus_addr == ADDR_W'(ppc_pkg::OFF_DIR));
  assign hit_lvl = (bus_addr == ADDR_W'(ppc_pkg::OFF_LEVEL));
  assign hit_rt  = (bus_addr == ADDR_W'(ppc_pkg::OFF_ROUTE));

  always_comb begin
    rd_mux = '0;
    if (hit_dir)      rd_mux = {{PAD_W{1'b0}}, dir_q};
    else if (hit_lvl) rd_mux = {{PAD_W{1'b0}}, state_q};
    else if (hit_rt)  rd_mux = {{RPAD_W{1'b0}}, route_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= '0;
      state_q   <= '0;
      route_q   <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && hit_dir) dir_q   <= bus_wdata[NUM_PINS-1:0];
      if (bus_we && hit_lvl) state_q <= bus_wdata[NUM_PINS-1:0];
      if (sleep_req)                route_q <= '0;
      else if (bus_we && hit_rt)    route_q <= bus_wdata[ROUTE_W-1:0];
      if (bus_re) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ppc_pin_mux.sv
module ppc_pin_mux #(
  parameter int NUM_PINS = 22,
  parameter logic [NUM_PINS-1:0] OUT_MASK = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] own_en,
  input  logic [NUM_PINS-1:0] dir_q,
  input  logic [NUM_PINS-1:0] state_q,
  input  logic [NUM_PINS-1:0] periph_do,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_do
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic oe_d, do_d;
    if (OUT_MASK[i]) begin : g_out
      assign oe_d = own_en[i] ? 1'b1 : dir_q[i];
      assign do_d = own_en[i] ? periph_do[i] : state_q[i];
    end else begin : g_in
      logic unused_pd;
      assign unused_pd = periph_do[i];
      assign oe_d = own_en[i] ? 1'b0 : dir_q[i];
      assign do_d = own_en[i] ? 1'b0 : state_q[i];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe[i] <= 1'b0;
        pin_do[i] <= 1'b0;
      end else begin
        pin_oe[i] <= oe_d;
        pin_do[i] <= do_d;
      end
    end
  end
endmodule

// File: rtl/ppc_alt_route.sv
module ppc_alt_route #(
  parameter int NUM_ALT = 6,
  parameter int ROUTE_W = 2,
  parameter logic [NUM_ALT-1:0] ALT_OUT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ROUTE_W-1:0] route_q,
  input  logic [3:0]         alt_tx_data,
  input  logic [NUM_ALT-1:0] gpio_in,
  output logic [NUM_ALT-1:0] alt_own,
  output logic [NUM_ALT-1:0] alt_oe,
  output logic [NUM_ALT-1:0] alt_do,
  output logic [1:0]         alt_rxd
);
  logic [NUM_ALT-1:0] own_d, src;
  logic [1:0]         rxd_d;
  logic               unused_in;

  assign unused_in = gpio_in[0] ^ gpio_in[2] ^ gpio_in[3] ^ gpio_in[4];

  // GPIO 10..13 for port 4, GPIO 14..15 for port 1
  assign own_d = {{2{route_q[0]}}, {4{route_q[1]}}};
  assign src   = {1'b0, alt_tx_data[3], alt_tx_data[2], alt_tx_data[1], 1'b0, alt_tx_data[0]};
  assign rxd_d = {route_q[0] ? gpio_in[5] : 1'b1,
                  route_q[1] ? gpio_in[1] : 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_own <= '0;
      alt_oe  <= '0;
      alt_do  <= '0;
      alt_rxd <= 2'b11;
    end else begin
      alt_own <= own_d;
      alt_oe  <= own_d & ALT_OUT;
      alt_do  <= own_d & ALT_OUT & src;
      alt_rxd <= rxd_d;
    end
  end
endmodule

// File: rtl/pin_owner_ctrl.sv
module pin_owner_ctrl #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sleep_req,
  input  logic                         bus_we,
  input  logic                         bus_re,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic                         lcd_en,
  input  logic                         p1_tx_en,
  input  logic                         p1_rx_en,
  input  logic                         p2_tx_en,
  input  logic                         p2_rx_en,
  input  logic                         p3_tx_en,
  input  logic                         p3_rx_en,
  input  logic                         p4_en,
  input  logic [ppc_pkg::NUM_PINS-1:0] periph_do,
  output logic [ppc_pkg::NUM_PINS-1:0] pin_oe,
  output logic [ppc_pkg::NUM_PINS-1:0] pin_do,
  input  logic [3:0]                   alt_tx_data,
  input  logic [ppc_pkg::NUM_ALT-1:0]  gpio_in,
  output logic [ppc_pkg::NUM_ALT-1:0]  alt_own,
  output logic [ppc_pkg::NUM_ALT-1:0]  alt_oe,
  output logic [ppc_pkg::NUM_ALT-1:0]  alt_do,
  output logic [1:0]                   alt_rxd
);
  localparam int NP = ppc_pkg::NUM_PINS;
  localparam int RW = ppc_pkg::ROUTE_W;

  logic [NP-1:0]             dir_q, state_q, own_en;
  logic [RW-1:0]             route_q;
  logic [ppc_pkg::NUM_EN-1:0] en_vec;

  assign en_vec = {p4_en, p3_rx_en, p3_tx_en, p2_rx_en, p2_tx_en,
                   p1_rx_en, p1_tx_en, lcd_en};

  for (genvar i = 0; i < NP; i++) begin : g_own
    localparam int OW = ppc_pkg::owner_idx(i);
    assign own_en[i] = en_vec[OW];
  end

  ppc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PINS(NP), .ROUTE_W(RW)) u_regs (
    .clk(clk), .rst(rst), .sleep_req(sleep_req),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dir_q(dir_q), .state_q(state_q), .route_q(route_q)
  );

  ppc_pin_mux #(.NUM_PINS(NP), .OUT_MASK(ppc_pkg::OWNED_OUT)) u_mux (
    .clk(clk), .rst(rst), .own_en(own_en), .dir_q(dir_q),
    .state_q(state_q), .periph_do(periph_do),
    .pin_oe(pin_oe), .pin_do(pin_do)
  );

  ppc_alt_route #(.NUM_ALT(ppc_pkg::NUM_ALT), .ROUTE_W(RW),
                  .ALT_OUT(ppc_pkg::ALT_OUT)) u_alt (
    .clk(clk), .rst(rst), .route_q(route_q), .alt_tx_data(alt_tx_data),
    .gpio_in(gpio_in), .alt_own(alt_own), .alt_oe(alt_oe),
    .alt_do(alt_do), .alt_rxd(alt_rxd)
  );
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
  parameter int DATA_W   = 32,
  parameter int NUM_PINS = 22,
  parameter int NUM_ALT  = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                sleep_req,
  input logic                lcd_en,
  input logic                p1_tx_en,
  input logic                p2_rx_en,
  input logic                p3_tx_en,
  input logic                p4_en,
  input logic [NUM_PINS-1:0] periph_do,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_do,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] state_q,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_ALT-1:0]  alt_own,
  input logic [NUM_ALT-1:0]  alt_oe
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && alt_own == '0));

  a_r2_released_follows_regs: assert property (@(posedge clk) disable iff (rst)
    !p3_tx_en |=> (pin_oe[16] == $past(dir_q[16]) && pin_do[16] == $past(state_q[16])));

  a_r3_lcd_drives: assert property (@(posedge clk) disable iff (rst)
    lcd_en |=> ((&pin_oe[11:0]) && pin_do[11:0] == $past(periph_do[11:0])));

  a_r4_tx_owned: assert property (@(posedge clk) disable iff (rst)
    p1_tx_en |=> (pin_oe[12] && pin_do[12] == $past(periph_do[12])));

  a_r4_rx_owned: assert property (@(posedge clk) disable iff (rst)
    p2_rx_en |=> (!pin_oe[15] && !pin_do[15]));

  a_r5_port4_dirs: assert property (@(posedge clk) disable iff (rst)
    p4_en |=> (pin_oe[21:18] == 4'b1101));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:NUM_PINS] == '0);

  a_r8_oe_within_own: assert property (@(posedge clk) disable iff (rst)
    (alt_oe & ~alt_own) == '0);

  a_r10_sleep_drops_route: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> ##1 (alt_own == '0));
endmodule

bind pin_owner_ctrl ppc_checker #(
  .DATA_W(DATA_W), .NUM_PINS(ppc_pkg::NUM_PINS), .NUM_ALT(ppc_pkg::NUM_ALT)
) u_chk (
  .clk(clk), .rst(rst), .sleep_req(sleep_req), .lcd_en(lcd_en),
  .p1_tx_en(p1_tx_en), .p2_rx_en(p2_rx_en), .p3_tx_en(p3_tx_en),
  .p4_en(p4_en), .periph_do(periph_do), .pin_oe(pin_oe), .pin_do(pin_do),
  .dir_q(dir_q), .state_q(state_q), .bus_rdata(bus_rdata),
  .alt_own(alt_own), .alt_oe(alt_oe)
);

// File: tb/test_pin_owner_ctrl.sv
module test_pin_owner_ctrl;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic [7:0]  en = '0;
  logic [21:0] periph_do = '0, pin_oe, pin_do;
  logic [3:0]  alt_tx_data = '0;
  logic [5:0]  gpio_in = '0, alt_own, alt_oe, alt_do;
  logic [1:0]  alt_rxd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_owner_ctrl #(.DATA_W(DW), .ADDR_W(AW)) i_pin_owner_ctrl (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .bus_we(bus_we),
    .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lcd_en(en[0]), .p1_tx_en(en[1]),
    .p1_rx_en(en[2]), .p2_tx_en(en[3]), .p2_rx_en(en[4]),
    .p3_tx_en(en[5]), .p3_rx_en(en[6]), .p4_en(en[7]),
    .periph_do(periph_do), .pin_oe(pin_oe), .pin_do(pin_do),
    .alt_tx_data(alt_tx_data), .gpio_in(gpio_in), .alt_own(alt_own),
    .alt_oe(alt_oe), .alt_do(alt_do), .alt_rxd(alt_rxd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = AW'(a);
    @(posedge clk); #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  // enable index owning each pad, per R3/R4/R5
  function automatic int own_of(input int i);
    if (i < 12) return 0;
    if (i < 18) return i - 11;
    return 7;
  endfunction

  function automatic bit drives(input int i);
    if (i < 12) return 1'b1;
    if (i < 18) return (i % 2) == 0;
    return i != 19;
  endfunction

  function automatic logic [21:0] exp_oe(input logic [7:0] e, input logic [21:0] d);
    logic [21:0] r;
    for (int i = 0; i < 22; i++) r[i] = e[own_of(i)] ? drives(i) : d[i];
    return r;
  endfunction

  function automatic logic [21:0] exp_do(input logic [7:0] e, input logic [21:0] s,
                                         input logic [21:0] p);
    logic [21:0] r;
    for (int i = 0; i < 22; i++) r[i] = e[own_of(i)] ? (drives(i) & p[i]) : s[i];
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [21:0] dirs [3];
    logic [21:0] lvls [3];
    dirs[0] = 22'h2A5C3F; dirs[1] = 22'h15A3C0; dirs[2] = 22'h3FFFFF;
    lvls[0] = 22'h0F0F0F; lvls[1] = 22'h30F0F0; lvls[2] = 22'h155555;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 oe", 64'(pin_oe), 64'h0);
    chk("R1 do", 64'(pin_do), 64'h0);
    chk("R1 alt_own", 64'(alt_own), 64'h0);
    chk("R1 alt_rxd", 64'(alt_rxd), 64'h3);
    rd(0, d); chk("R1 dir read", 64'(d), 64'h0);
    rd(1, d); chk("R1 level read", 64'(d), 64'h0);
    rd(2, d); chk("R1 route read", 64'(d), 64'h0);

    // R6 reserved bits and unmapped offsets
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R6 dir reserved", 64'(d), 64'h003F_FFFF);
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); chk("R6 route reserved", 64'(d), 64'h3);
    wr(3, 32'hFFFF_FFFF);
    rd(3, d); chk("R6 unmapped", 64'(d), 64'h0);
    wr(2, 32'h0);
    wr(0, 32'h0);
    settle();

    // R11 write latency: register at edge 1, pad at edge 2
    @(negedge clk); bus_we = 1'b1; bus_addr = 0; bus_wdata = 32'h1;
    @(posedge clk); #1 chk("R11 first edge", 64'(pin_oe[0]), 64'h0);
    @(negedge clk); bus_we = 1'b0;
    @(posedge clk); #1 chk("R11 second edge", 64'(pin_oe[0]), 64'h1);

    // R2 R3 R4 R5: sweep all enable combinations
    for (int p = 0; p < 3; p++) begin
      wr(0, 32'(dirs[p]));
      wr(1, 32'(lvls[p]));
      for (int e = 0; e < 256; e++) begin
        @(negedge clk);
        en = 8'(e);
        periph_do = {8'(e), 6'(e * 5), 8'(~e)} ^ 22'(p * 22'h12345);
        settle();
        chk("R2 R3 R4 R5 oe", 64'(pin_oe), 64'(exp_oe(en, dirs[p])));
        chk("R2 R3 R4 R5 do", 64'(pin_do), 64'(exp_do(en, lvls[p], periph_do)));
      end
    end

    // R7 readback independent of enables
    @(negedge clk); en = 8'hFF;
    rd(0, d); chk("R7 dir with enables", 64'(d), 64'(dirs[2]));
    rd(1, d); chk("R7 level with enables", 64'(d), 64'(lvls[2]));
    @(negedge clk); en = 8'h00;

    // R8 R9 routes
    for (int r = 0; r < 4; r++) begin
      wr(2, 32'(r));
      for (int g = 0; g < 64; g++) begin
        logic [5:0] own_e, do_e;
        logic [1:0] rx_e;
        @(negedge clk);
        gpio_in = 6'(g);
        alt_tx_data = 4'(g ^ (g >> 2));
        settle();
        own_e = {{2{r[0]}}, {4{r[1]}}};
        do_e  = own_e & {1'b0, alt_tx_data[3], alt_tx_data[2], alt_tx_data[1],
                         1'b0, alt_tx_data[0]};
        rx_e  = {r[0] ? gpio_in[5] : 1'b1, r[1] ? gpio_in[1] : 1'b1};
        chk("R8 R9 own", 64'(alt_own), 64'(own_e));
        chk("R8 R9 oe", 64'(alt_oe), 64'(own_e & 6'b011101));
        chk("R8 R9 do", 64'(alt_do), 64'(do_e));
        chk("R8 R9 rxd", 64'(alt_rxd), 64'(rx_e));
      end
    end

    // R10 sleep clears route, even against a simultaneous write
    wr(2, 32'h3);
    settle();
    chk("R10 route set", 64'(alt_own), 64'h3F);
    @(negedge clk); sleep_req = 1'b1; bus_we = 1'b1; bus_addr = 2; bus_wdata = 32'h3;
    @(negedge clk); sleep_req = 1'b0; bus_we = 1'b0;
    settle();
    chk("R10 alt_own cleared", 64'(alt_own), 64'h0);
    chk("R10 alt_rxd idle", 64'(alt_rxd), 64'h3);
    rd(2, d); chk("R10 route read", 64'(d), 64'h0);
    rd(0, d); chk("R10 dir kept", 64'(d), 64'(dirs[2]));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule